// File: doc/BRIEF.md
# Saturating Add and Shift Unit

This block is an integer arithmetic unit for a 32-bit datapath. It performs saturating add in signed and unsigned flavours, signed saturating subtract, and saturating left shifts in signed and unsigned flavours. When the true mathematical result of an operation does not fit in the result width, the output is pinned to the nearest representable limit instead of wrapping around.

Every arithmetic path widens its intermediate value before deciding whether to clamp. Add and subtract use one extra bit. Shifts use a double-width value. Overflow is therefore found by comparing the widened value against the limits, not by inspecting a wrapped result. The unit sits after operand fetch. It receives two operands and a 3-bit operation code, and it delivers the result through an optional output register. Decode and register-file access are handled elsewhere.

Top module: `sat_alu`

## Requirements
- R1: While reset is asserted, and until the internally synchronised reset is released, `res_o` is zero.
- R2: With the default `OUT_REG = 1`, `res_o` shows the result for the operands and code that were present at a rising clock edge, once that edge has passed. Codes: 0 = signed add, 1 = unsigned add, 2 = signed subtract, 3 = signed shift left, 4 = unsigned shift left.
- R3: Code 0 returns the exact sum `a + b` whenever that sum lies within the signed range.
- R4: Code 0 returns 0x7FFFFFFF when two non-negative operands overflow. It returns 0x80000000 when two negative operands overflow.
- R5: Code 1 treats both operands as unsigned. It returns the sum when the sum fits in 32 bits, and 0xFFFFFFFF otherwise.
- R6: Code 2 returns `a - b` in signed arithmetic. The result clamps to 0x7FFFFFFF above the range and to 0x80000000 below it.
- R7: Code 3 shifts the signed operand `a` left by `b[4:0]`. It clamps to 0x7FFFFFFF or 0x80000000 when the true product falls outside the signed range. Bits `b[31:5]` have no effect.
- R8: Code 4 shifts `a`, zero-extended, left by `b[4:0]`. It returns 0xFFFFFFFF when the true value exceeds the unsigned range. A set top bit of `a` is never treated as a sign.
- R9: For codes 3 and 4, a shift amount of 0 returns `a` unchanged.
- R10: Codes 5, 6 and 7 produce zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code |
| a_i | input | XLEN | First operand, and the value that is shifted |
| b_i | input | XLEN | Second operand; its low bits give the shift amount |
| res_o | output | XLEN | Saturated result |

## Verification
A faulty overflow test or clamp selection in this unit shows up at the ports as a wrapped value where a limit was due, or as a limit where an exact result was due. It appears one clock after the offending operands are applied, because the only state is the output register. Boundary operands target each limit and the values just inside it. Random operands across all eight codes catch carry and sign-extension errors in the widened intermediates. A wrong extension of a shifted operand shows up as a false signed clamp on large unsigned values.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [2:0] {
    OP_ADD_S = 3'd0,
    OP_ADD_U = 3'd1,
    OP_SUB_S = 3'd2,
    OP_SHL_S = 3'd3,
    OP_SHL_U = 3'd4
  } sat_op_e;

  localparam int unsigned OP_LAST_USED = 4;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  input  logic            uns,
  output logic [XLEN-1:0] res
);
  localparam int unsigned W = XLEN + 1;
  localparam logic [W-1:0] UMAX_W = {1'b0, {XLEN{1'b1}}};
  localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};

  logic [W-1:0] ea, eb, wide;
  logic         s_ovf;

  always_comb begin
    ea    = uns ? {1'b0, a} : {a[XLEN-1], a};
    eb    = uns ? {1'b0, b} : {b[XLEN-1], b};
    wide  = sub ? (ea - eb) : (ea + eb);
    // the widened sign disagrees with the narrow sign only when out of range
    s_ovf = wide[W-1] ^ wide[XLEN-1];
    if (uns) begin
      res = (wide > UMAX_W) ? {XLEN{1'b1}} : wide[XLEN-1:0];
    end else if (s_ovf) begin
      res = wide[W-1] ? SMIN : SMAX;
    end else begin
      res = wide[XLEN-1:0];
    end
  end
endmodule

// File: rtl/sat_shl.sv
module sat_shl #(
  parameter int unsigned XLEN   = 32,
  parameter bit          SIGNED = 1'b1
) (
  input  logic [XLEN-1:0]         a,
  input  logic [$clog2(XLEN)-1:0] sh,
  output logic [XLEN-1:0]         res
);
  localparam int unsigned DW = 2 * XLEN;
  localparam logic [DW-1:0] LIM_P = {{(XLEN+1){1'b0}}, {(XLEN-1){1'b1}}};
  localparam logic [DW-1:0] LIM_N = ~LIM_P;
  localparam logic [DW-1:0] LIM_U = {{XLEN{1'b0}}, {XLEN{1'b1}}};

  logic [DW-1:0] ext, wide;

  generate
    if (SIGNED) begin : g_signed
      always_comb begin
        ext  = {{XLEN{a[XLEN-1]}}, a};
        wide = ext << sh;
        if ($signed(wide) > $signed(LIM_P))      res = LIM_P[XLEN-1:0];
        else if ($signed(wide) < $signed(LIM_N)) res = LIM_N[XLEN-1:0];
        else                                     res = wide[XLEN-1:0];
      end
    end else begin : g_unsigned
      always_comb begin
        ext  = {{XLEN{1'b0}}, a};
        wide = ext << sh;
        res  = (wide > LIM_U) ? {XLEN{1'b1}} : wide[XLEN-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [XLEN-1:0] as_res;
  logic [XLEN-1:0] shl_res [2];
  logic [XLEN-1:0] res_d;
  logic            as_sub, as_uns;
  logic [1:0]      rst_sync;
  logic            rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    as_sub = (op_i == OP_SUB_S);
    as_uns = (op_i == OP_ADD_U);
  end

  sat_addsub #(.XLEN(XLEN)) u_addsub (
    .a   (a_i),
    .b   (b_i),
    .sub (as_sub),
    .uns (as_uns),
    .res (as_res)
  );

  // index 0: unsigned shifter, index 1: signed shifter
  generate
    for (genvar g = 0; g < 2; g++) begin : g_shl
      sat_shl #(.XLEN(XLEN), .SIGNED(g != 0)) u_shl (
        .a   (a_i),
        .sh  (b_i[SHW-1:0]),
        .res (shl_res[g])
      );
    end
  endgenerate

  always_comb begin
    case (op_i)
      OP_ADD_S, OP_ADD_U, OP_SUB_S: res_d = as_res;
      OP_SHL_S:                     res_d = shl_res[1];
      OP_SHL_U:                     res_d = shl_res[0];
      default:                      res_d = '0;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [XLEN-1:0] res_q;
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) res_q <= '0;
        else            res_q <= res_d;
      end
      assign res_o = res_q;
    end else begin : g_comb
      assign res_o = res_d;
    end
  endgenerate
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int unsigned XLEN    = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] res_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [2:0]      p_op;
  logic [XLEN-1:0] p_a, p_b;
  logic [2:0]      vld_sr;
  logic            p_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_sr <= 3'b000;
    else        vld_sr <= {vld_sr[1:0], 1'b1};
  end
  assign p_vld = vld_sr[2];

  generate
    if (OUT_REG) begin : g_cap
      always_ff @(posedge clk) begin
        p_op <= op_i;
        p_a  <= a_i;
        p_b  <= b_i;
      end
    end else begin : g_pass
      assign p_op = op_i;
      assign p_a  = a_i;
      assign p_b  = b_i;
    end
  endgenerate

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_op > 3'd4) |-> (res_o == '0));

  a_r5_addu_not_below: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_op == 3'd1) |-> (res_o >= p_a && res_o >= p_b));

  a_r3_mixed_sign_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_op == 3'd0 && (p_a[XLEN-1] != p_b[XLEN-1])) |-> (res_o == p_a + p_b));

  a_r4_pos_stays_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_op == 3'd0 && !p_a[XLEN-1] && !p_b[XLEN-1]) |-> !res_o[XLEN-1]);

  a_r9_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && (p_op == 3'd3 || p_op == 3'd4) && p_b[SHW-1:0] == '0) |-> (res_o == p_a));

  a_r8_shlu_not_below: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && p_op == 3'd4) |-> (res_o >= p_a));
endmodule

bind sat_alu sat_alu_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_sat_alu_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_i  (op_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .res_o (res_o)
);

// File: tb/sat_alu_bench.sv
`timescale 1ns/1ps
module sat_alu_bench;
  localparam int unsigned XW = 32;
  localparam int unsigned WD_CYCLES = 50000;

  logic          clk;
  logic          rst_n;
  logic [2:0]    op_i;
  logic [XW-1:0] a_i, b_i;
  logic [XW-1:0] res_o;

  int n_run;
  int n_fail;
  bit done;

  sat_alu #(.XLEN(XW), .OUT_REG(1'b1)) u_sat_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(res_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [XW-1:0] model(input logic [2:0] op, input logic [XW-1:0] a,
                                           input logic [XW-1:0] b);
    longint       sa, sb, s;
    logic [63:0]  u;
    int           sh;
    longint       smax, smin;
    smax = 64'sd2147483647;
    smin = -64'sd2147483648;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sh = int'(b[4:0]);
    case (op)
      3'd0: begin s = sa + sb; model = (s > smax) ? 32'h7FFFFFFF : (s < smin) ? 32'h80000000 : s[31:0]; end
      3'd1: begin u = {32'd0, a} + {32'd0, b}; model = (u > 64'hFFFFFFFF) ? 32'hFFFFFFFF : u[31:0]; end
      3'd2: begin s = sa - sb; model = (s > smax) ? 32'h7FFFFFFF : (s < smin) ? 32'h80000000 : s[31:0]; end
      3'd3: begin s = sa * (64'sd1 <<< sh); model = (s > smax) ? 32'h7FFFFFFF : (s < smin) ? 32'h80000000 : s[31:0]; end
      3'd4: begin u = {32'd0, a} << sh; model = (u > 64'hFFFFFFFF) ? 32'hFFFFFFFF : u[31:0]; end
      default: model = '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [XW-1:0] got, input logic [XW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [XW-1:0] a, input logic [XW-1:0] b,
                       input string req);
    logic [XW-1:0] exp;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    exp = model(op, a, b);
    @(posedge clk);
    #5;
    check(req, res_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; op_i = 3'd0; a_i = 32'd5; b_i = 32'd3;
    repeat (3) @(posedge clk);
    #5;
    check("R1", res_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R1", res_o, 32'd0);
    repeat (4) @(posedge clk);

    // R3 exact signed sums
    apply(3'd0, 32'd5, 32'd7, "R3");
    apply(3'd0, 32'hFFFFFFFD, 32'd10, "R3");
    apply(3'd0, 32'h7FFFFFFE, 32'd1, "R3");
    // R4 signed add clamps
    apply(3'd0, 32'h7FFFFFFF, 32'd1, "R4");
    apply(3'd0, 32'h80000000, 32'hFFFFFFFF, "R4");
    apply(3'd0, 32'h80000000, 32'h80000000, "R4");
    // R5 unsigned add
    apply(3'd1, 32'd1, 32'd2, "R5");
    apply(3'd1, 32'hFFFFFFFF, 32'd1, "R5");
    apply(3'd1, 32'h80000000, 32'h80000000, "R5");
    apply(3'd1, 32'hFFFFFFFE, 32'd1, "R5");
    // R6 signed subtract
    apply(3'd2, 32'd10, 32'd3, "R6");
    apply(3'd2, 32'h80000000, 32'd1, "R6");
    apply(3'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, "R6");
    apply(3'd2, 32'd0, 32'h80000000, "R6");
    // R7 signed shift
    apply(3'd3, 32'd1, 32'd31, "R7");
    apply(3'd3, 32'hFFFFFFFF, 32'd31, "R7");
    apply(3'd3, 32'hC0000000, 32'd1, "R7");
    apply(3'd3, 32'h40000000, 32'd1, "R7");
    apply(3'd3, 32'd3, 32'hFFFFFFE5, "R7");
    // R8 unsigned shift
    apply(3'd4, 32'h80000000, 32'd1, "R8");
    apply(3'd4, 32'd1, 32'd31, "R8");
    apply(3'd4, 32'hF0000000, 32'h00000020, "R8");
    apply(3'd4, 32'h0000FFFF, 32'h00000010, "R8");
    // R9 zero shift amount
    apply(3'd3, 32'hDEADBEEF, 32'h00000020, "R9");
    apply(3'd4, 32'hDEADBEEF, 32'hFFFFFFE0, "R9");
    // R10 unused codes
    apply(3'd5, 32'h12345678, 32'd9, "R10");
    apply(3'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10");
    apply(3'd7, 32'h7FFFFFFF, 32'd1, "R10");

    // R2 random codes and operands, one result per clock
    for (int i = 0; i < 3000; i++) begin
      logic [XW-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) ra = {ra[31], {31{ra[30]}}};
      apply(3'($urandom_range(0, 7)), ra, rb, "R2");
    end

    finish_run();
  end
endmodule